// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache with Line Buffer

This block is a read-only instruction cache between a 32-bit fetch port and an external memory that returns bursts. It holds 256 lines of 16 bytes each. Every line has a tag and one valid bit, and the data store is 1024 words of 32 bits. A line buffer of four words runs alongside the arrays. Each fetch is checked against the arrays and the buffer in the same cycle, and a hit in either one answers in that cycle with `fetch_rdy` high.

When a fetch misses both the arrays and the buffer, the block issues one burst request for the whole line, starting at the missed word. Beats are stored in the line buffer as they arrive, and each buffer word has its own valid bit. A fetch whose word is on the memory bus in the current cycle is answered straight from that beat. A fetch whose word arrived earlier is answered from the buffer. Once all four words are present, the line is written into the arrays in one step. A single invalidate input drops every valid bit in the arrays and in the buffer.

Top module: `ifetch_cache`

## Requirements
- R1: Address fields are: bits [1:0] byte offset (ignored), bits [3:2] word in line, bits [11:4] line index, bits [31:12] tag. Two lines with equal index and different tags share one slot, and installing one evicts the other.
- R2: A fetch to an installed line gets `fetch_rdy` high with the correct word in the same cycle as `fetch_req`, and `mem_req` stays low.
- R3: When no fill is in progress, a fetch that misses raises `mem_req` in that same cycle for exactly one cycle. `mem_addr` is the fetch address with bits [1:0] cleared.
- R4: Memory returns four beats on `mem_beat_vld`, which may have idle cycles between them. The first beat is the requested word and the rest follow in the order word+1, word+2, word+3, modulo four. Every word is stored and later served at its correct position.
- R5: The fetch that caused a miss is answered in the cycle its first beat is on the bus.
- R6: A fetch to the line being filled never starts a second burst. A word that already arrived is served in the same cycle, and a word not yet arrived is served in the cycle its beat arrives.
- R7: After the fourth beat, the line is written into the arrays with its valid bit set, and later fetches to it hit in one cycle.
- R8: A miss to another line while a fill or its install cycle is pending waits with `fetch_rdy` low. It raises `mem_req` only once the block is idle.
- R9: While `inval_all` is high, `fetch_rdy` and `mem_req` are low. On the next edge, every array valid bit and every buffer valid bit is cleared, so a line installed before must be fetched again.
- R10: An invalidate during a fill lets the remaining beats be absorbed but not marked valid, and the line is not installed.
- R11: Synchronous reset leaves the block idle with no valid line, so the first fetch after reset misses. `fetch_rdy` and `mem_req` are low after reset while no fetch is requested.
- R12: `fetch_rdy` is high only while `fetch_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inval_all | input | 1 | Clear all array and buffer valid bits |
| fetch_req | input | 1 | Fetch request, held until `fetch_rdy` |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_rdy | output | 1 | Fetch answered this cycle |
| fetch_data | output | 32 | Instruction word, valid with `fetch_rdy` |
| mem_req | output | 1 | One-cycle line burst request |
| mem_addr | output | 32 | Address of the first word of the burst |
| mem_beat_vld | input | 1 | Burst beat present |
| mem_beat_data | input | 32 | Burst beat word |

## Verification
Each fetch leaves two marks at the ports: the word returned and the number of cycles until `fetch_rdy`. A bad tag, index or valid bit shows up on the fetch it affects. It appears either as a hit that comes one or more cycles late together with a needless `mem_req`, or as a word from the wrong line. A wrong word position in the buffer gives a data mismatch on the first fetch that reads that word. A sequencer that loses count appears as a second `mem_req` during a fill, or as a following miss that never gets answered. All of these appear within a few cycles of the fill that caused them.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

    localparam int IFC_ADDR_W     = 32;
    localparam int IFC_WORD_W     = 32;
    localparam int IFC_LINE_BYTES = 16;
    localparam int IFC_NUM_LINES  = 256;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_FILL   = 2'd1,
        SQ_COMMIT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic arr;
        logic fbuf;
        logic beat;
    } hit_src_t;

    function automatic logic any_hit(input hit_src_t h);
        return h.arr | h.fbuf | h.beat;
    endfunction

endpackage

// File: rtl/ifc_tag_store.sv
module ifc_tag_store #(
    parameter int NUM_LINES = 256,
    parameter int IDX_W     = 8,
    parameter int TAG_W     = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inval,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [NUM_LINES-1:0] vld_q;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];

    always_ff @(posedge clk) begin
        if (rst || inval) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign hit = vld_q[look_idx] && (tag_q[look_idx] == look_tag);

    // R9
    tags_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        inval |=> (vld_q == '0));

    // R7
    install_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !inval) |=> (vld_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag))));

endmodule

// File: rtl/ifc_data_store.sv
module ifc_data_store #(
    parameter int NUM_LINES  = 256,
    parameter int IDX_W      = 8,
    parameter int LINE_WORDS = 4,
    parameter int WSEL_W     = 2,
    parameter int WORD_W     = 32
) (
    input  logic                                clk,
    input  logic [IDX_W-1:0]                    rd_idx,
    input  logic [WSEL_W-1:0]                   rd_wsel,
    output logic [WORD_W-1:0]                   rd_word,
    input  logic                                wr_en,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [LINE_WORDS-1:0][WORD_W-1:0]   wr_line
);

    logic [LINE_WORDS-1:0][WORD_W-1:0] line_q [NUM_LINES];
    logic [LINE_WORDS-1:0][WORD_W-1:0] rd_line;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[wr_idx] <= wr_line;
        end
    end

    assign rd_line = line_q[rd_idx];
    assign rd_word = rd_line[rd_wsel];

endmodule

// File: rtl/ifc_line_buf.sv
module ifc_line_buf #(
    parameter int LADDR_W    = 28,
    parameter int LINE_WORDS = 4,
    parameter int WSEL_W     = 2,
    parameter int WORD_W     = 32
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              inval,
    input  logic                              start,
    input  logic [LADDR_W-1:0]                start_line,
    input  logic                              beat_vld,
    input  logic [WSEL_W-1:0]                 beat_wsel,
    input  logic [WORD_W-1:0]                 beat_data,
    input  logic [LADDR_W-1:0]                look_line,
    input  logic [WSEL_W-1:0]                 look_wsel,
    output logic                              hit,
    output logic [WORD_W-1:0]                 hit_word,
    output logic                              live,
    output logic                              full,
    output logic [LADDR_W-1:0]                line,
    output logic [LINE_WORDS-1:0][WORD_W-1:0] line_words
);

    logic [LINE_WORDS-1:0]             vld_q;
    logic                              live_q;
    logic [LADDR_W-1:0]                line_q;
    logic [LINE_WORDS-1:0][WORD_W-1:0] words_q;

    always_ff @(posedge clk) begin
        if (rst || inval) begin
            vld_q  <= '0;
            live_q <= 1'b0;
        end else if (start) begin
            vld_q  <= '0;
            live_q <= 1'b1;
            line_q <= start_line;
        end else if (beat_vld && live_q) begin
            vld_q[beat_wsel] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (beat_vld) begin
            words_q[beat_wsel] <= beat_data;
        end
    end

    assign hit        = live_q && (line_q == look_line) && vld_q[look_wsel];
    assign hit_word   = words_q[look_wsel];
    assign live       = live_q;
    assign full       = &vld_q;
    assign line       = line_q;
    assign line_words = words_q;

    // R6
    fresh_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !inval) |=> (live_q && (vld_q == '0)));

    // R10
    dropped_fill_chk: assert property (@(posedge clk) disable iff (rst)
        inval |=> (!live_q && (vld_q == '0)));

endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache
    import ifc_pkg::*;
#(
    parameter int ADDR_W     = IFC_ADDR_W,
    parameter int WORD_W     = IFC_WORD_W,
    parameter int LINE_BYTES = IFC_LINE_BYTES,
    parameter int NUM_LINES  = IFC_NUM_LINES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inval_all,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_rdy,
    output logic [WORD_W-1:0] fetch_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_beat_vld,
    input  logic [WORD_W-1:0] mem_beat_data
);

    localparam int WORD_BYTES = WORD_W / 8;
    localparam int BOFF_W     = $clog2(WORD_BYTES);
    localparam int LINE_WORDS = LINE_BYTES / WORD_BYTES;
    localparam int WSEL_W     = $clog2(LINE_WORDS);
    localparam int IDX_W      = $clog2(NUM_LINES);
    localparam int LADDR_W    = ADDR_W - WSEL_W - BOFF_W;
    localparam int TAG_W      = LADDR_W - IDX_W;

    // fetch address fields
    logic [LADDR_W-1:0] f_line;
    logic [TAG_W-1:0]   f_tag;
    logic [IDX_W-1:0]   f_idx;
    logic [WSEL_W-1:0]  f_wsel;
    logic               unused_boff;

    assign f_line      = fetch_addr[ADDR_W-1 -: LADDR_W];
    assign f_tag       = f_line[LADDR_W-1 -: TAG_W];
    assign f_idx       = f_line[IDX_W-1:0];
    assign f_wsel      = fetch_addr[BOFF_W +: WSEL_W];
    assign unused_boff = ^fetch_addr[BOFF_W-1:0];

    // sequencer state
    seq_state_e        state_q;
    logic [WSEL_W-1:0] start_q;
    logic [WSEL_W-1:0] cnt_q;
    logic [WSEL_W-1:0] beat_wsel;
    logic              fill_beat;
    logic              miss_go;
    logic              commit_en;

    // line buffer outputs
    logic                              fb_hit;
    logic [WORD_W-1:0]                 fb_word;
    logic                              fb_live;
    logic                              fb_full;
    logic [LADDR_W-1:0]                fb_line;
    logic [LINE_WORDS-1:0][WORD_W-1:0] fb_words;

    // array outputs
    logic              arr_hit;
    logic [WORD_W-1:0] arr_word;

    hit_src_t hs;

    assign beat_wsel = start_q + cnt_q;
    assign fill_beat = mem_beat_vld && (state_q == SQ_FILL);

    always_comb begin
        hs.arr  = arr_hit;
        hs.fbuf = fb_hit;
        hs.beat = fill_beat && fb_live && (fb_line == f_line) && (beat_wsel == f_wsel);
    end

    assign fetch_rdy = fetch_req && !inval_all && any_hit(hs);

    always_comb begin
        if (hs.arr) begin
            fetch_data = arr_word;
        end else if (hs.fbuf) begin
            fetch_data = fb_word;
        end else begin
            fetch_data = mem_beat_data;
        end
    end

    assign miss_go   = fetch_req && !inval_all && !any_hit(hs) && (state_q == SQ_IDLE);
    assign mem_req   = miss_go;
    assign mem_addr  = {f_line, f_wsel, {BOFF_W{1'b0}}};
    assign commit_en = (state_q == SQ_COMMIT) && fb_live && fb_full && !inval_all;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            start_q <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (miss_go) begin
                        state_q <= SQ_FILL;
                        start_q <= f_wsel;
                        cnt_q   <= '0;
                    end
                end
                SQ_FILL: begin
                    if (fill_beat) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == WSEL_W'(LINE_WORDS - 1)) begin
                            state_q <= SQ_COMMIT;
                        end
                    end
                end
                SQ_COMMIT: state_q <= SQ_IDLE;
                default:   state_q <= SQ_IDLE;
            endcase
        end
    end

    ifc_tag_store #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W),
        .TAG_W     (TAG_W)
    ) i_tags (
        .clk      (clk),
        .rst      (rst),
        .inval    (inval_all),
        .look_idx (f_idx),
        .look_tag (f_tag),
        .hit      (arr_hit),
        .wr_en    (commit_en),
        .wr_idx   (fb_line[IDX_W-1:0]),
        .wr_tag   (fb_line[LADDR_W-1 -: TAG_W])
    );

    ifc_data_store #(
        .NUM_LINES  (NUM_LINES),
        .IDX_W      (IDX_W),
        .LINE_WORDS (LINE_WORDS),
        .WSEL_W     (WSEL_W),
        .WORD_W     (WORD_W)
    ) i_data (
        .clk     (clk),
        .rd_idx  (f_idx),
        .rd_wsel (f_wsel),
        .rd_word (arr_word),
        .wr_en   (commit_en),
        .wr_idx  (fb_line[IDX_W-1:0]),
        .wr_line (fb_words)
    );

    ifc_line_buf #(
        .LADDR_W    (LADDR_W),
        .LINE_WORDS (LINE_WORDS),
        .WSEL_W     (WSEL_W),
        .WORD_W     (WORD_W)
    ) i_lbuf (
        .clk        (clk),
        .rst        (rst),
        .inval      (inval_all),
        .start      (miss_go),
        .start_line (f_line),
        .beat_vld   (fill_beat),
        .beat_wsel  (beat_wsel),
        .beat_data  (mem_beat_data),
        .look_line  (f_line),
        .look_wsel  (f_wsel),
        .hit        (fb_hit),
        .hit_word   (fb_word),
        .live       (fb_live),
        .full       (fb_full),
        .line       (fb_line),
        .line_words (fb_words)
    );

    // R3
    burst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != SQ_IDLE) |-> !mem_req);

    // R9
    inval_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        inval_all |-> (!fetch_rdy && !mem_req));

    // R12
    rdy_req_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_rdy |-> fetch_req);

    // R4
    four_beats_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == SQ_COMMIT) |-> $past(fill_beat));

endmodule

// File: tb/test_ifetch_cache.sv
module test_ifetch_cache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        inval_all = 1'b0;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_rdy;
    logic [31:0] fetch_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_beat_vld = 1'b0;
    logic [31:0] mem_beat_data = '0;

    always #10 clk = ~clk;

    ifetch_cache i_ifetch_cache (
        .clk           (clk),
        .rst           (rst),
        .inval_all     (inval_all),
        .fetch_req     (fetch_req),
        .fetch_addr    (fetch_addr),
        .fetch_rdy     (fetch_rdy),
        .fetch_data    (fetch_data),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_beat_vld  (mem_beat_vld),
        .mem_beat_data (mem_beat_data)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // burst responder state
    bit          b_active = 0;
    bit          b_dead   = 0;
    logic [27:0] b_line   = '0;
    logic [1:0]  b_w      = '0;
    int          b_left   = 0;
    int          b_delay  = 0;
    bit          gaps     = 0;
    bit          rnd_lat  = 0;
    bit          c_pend   = 0;
    bit          c_dead   = 0;
    logic [27:0] c_line   = '0;

    // expected cache contents
    bit          m_vld [256];
    logic [19:0] m_tag [256];

    // sampled outputs
    bit          s_rdy, s_mreq, s_first;
    logic [31:0] s_data, s_maddr;

    function automatic logic [31:0] memw(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        return (w * 32'h9E3779B1) ^ {w[15:0], w[31:16]};
    endfunction

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL R8 watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    task automatic step();
        bit fin;
        bit busy;
        fin     = 0;
        s_first = 0;
        busy    = b_active || c_pend;
        mem_beat_vld  = 1'b0;
        mem_beat_data = '0;
        if (b_active) begin
            if (b_delay > 0) begin
                b_delay--;
            end else if (!(gaps && ($urandom % 4 == 0))) begin
                mem_beat_vld  = 1'b1;
                mem_beat_data = memw({b_line, b_w, 2'b00});
                s_first = (b_left == 4);
                b_w++;
                b_left--;
                if (b_left == 0) begin
                    b_active = 0;
                    fin = 1;
                end
            end
        end
        #1;
        s_rdy   = (fetch_rdy === 1'b1);
        s_mreq  = (mem_req === 1'b1);
        s_data  = fetch_data;
        s_maddr = mem_addr;
        if (!rst) begin
            if (!fetch_req) chk(!s_rdy, "R12", 32'(s_rdy), 0);
            if (inval_all) chk(!s_rdy && !s_mreq, "R9", {s_rdy, s_mreq}, 0);
            if (c_pend) begin
                if (!inval_all && !c_dead) begin
                    m_vld[c_line[7:0]] = 1;
                    m_tag[c_line[7:0]] = c_line[27:8];
                end
                c_pend = 0;
            end
            if (inval_all) begin
                foreach (m_vld[i]) m_vld[i] = 0;
                b_dead = 1;
            end
            if (fin) begin
                c_pend = 1;
                c_line = b_line;
                c_dead = b_dead;
            end
            if (s_mreq) begin
                chk(!busy, "R8", 32'(busy), 0);
                b_active = 1;
                b_dead   = 0;
                b_line   = s_maddr[31:4];
                b_w      = s_maddr[3:2];
                b_left   = 4;
                b_delay  = rnd_lat ? int'($urandom % 4) : 1;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        fetch_req = 1'b0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_fetch(input logic [31:0] a, output int lat, output int nreq);
        bit cached, fresh;
        cached = m_vld[a[11:4]] && (m_tag[a[11:4]] == a[31:12]);
        fresh  = !cached && !b_active && !c_pend;
        fetch_req  = 1'b1;
        fetch_addr = a;
        lat  = 0;
        nreq = 0;
        forever begin
            step();
            if (s_mreq) nreq++;
            if (lat == 0 && fresh)
                chk(s_mreq && (s_maddr == {a[31:2], 2'b00}), "R3", s_maddr, {a[31:2], 2'b00});
            if (s_rdy) break;
            lat++;
            if (lat > 80) begin
                chk(0, "R8 fetch never answered", 32'(lat), 80);
                break;
            end
        end
        if (s_rdy) chk(s_data == memw(a), "R4", s_data, memw(a));
        if (cached) chk(lat == 0 && nreq == 0, "R2", 32'(lat), 0);
        if (fresh && s_rdy) chk(s_first, "R5", 32'(s_first), 1);
        fetch_req = 1'b0;
    endtask

    initial begin
        int lat, nreq;
        foreach (m_vld[i]) m_vld[i] = 0;
        @(negedge clk);
        step();
        step();
        rst = 1'b0;
        step();
        chk(!s_rdy && !s_mreq, "R11", {s_rdy, s_mreq}, 0);

        // miss at word 2 after reset, then same-line fetches during fill
        do_fetch(32'h0000_1238, lat, nreq);
        chk(nreq == 1 && lat == 2, "R11", 32'(nreq), 1);
        do_fetch(32'h0000_1234, lat, nreq);
        chk(nreq == 0 && lat == 2, "R6", 32'(lat), 2);
        do_fetch(32'h0000_1230, lat, nreq);
        chk(nreq == 0 && lat == 0, "R6", 32'(lat), 0);
        do_fetch(32'h0000_123C, lat, nreq);
        chk(nreq == 0 && lat == 0, "R6", 32'(lat), 0);
        idle(1);
        do_fetch(32'h0000_1238, lat, nreq);
        chk(nreq == 0 && lat == 0, "R7", 32'(lat), 0);

        // same index, different tag evicts
        do_fetch(32'h0000_5238, lat, nreq);
        chk(nreq == 1, "R1", 32'(nreq), 1);
        idle(6);
        do_fetch(32'h0000_1238, lat, nreq);
        chk(nreq == 1, "R1", 32'(nreq), 1);
        idle(6);

        // other-line miss while a fill is pending
        do_fetch(32'h0000_2000, lat, nreq);
        do_fetch(32'h0000_3000, lat, nreq);
        chk(nreq == 1 && lat == 6, "R8", 32'(lat), 6);
        idle(6);
        do_fetch(32'h0000_3000, lat, nreq);
        chk(lat == 0, "R2", 32'(lat), 0);

        // invalidate with a fetch pending in the same cycle
        inval_all  = 1'b1;
        fetch_req  = 1'b1;
        fetch_addr = 32'h0000_3000;
        step();
        inval_all  = 1'b0;
        fetch_req  = 1'b0;
        do_fetch(32'h0000_3000, lat, nreq);
        chk(nreq == 1, "R9", 32'(nreq), 1);

        // invalidate in the middle of that fill
        inval_all = 1'b1;
        step();
        inval_all = 1'b0;
        idle(8);
        do_fetch(32'h0000_3004, lat, nreq);
        chk(nreq == 1, "R10", 32'(nreq), 1);
        idle(6);

        // random traffic
        void'($urandom(32'd1234));
        gaps    = 1;
        rnd_lat = 1;
        for (int k = 0; k < 400; k++) begin
            logic [31:0] a;
            a = {18'd0, 2'($urandom % 3), 4'd0, 4'(4 + $urandom % 4), 2'($urandom % 4), 2'($urandom % 4)};
            if ($urandom % 25 == 0) begin
                inval_all = 1'b1;
                step();
                inval_all = 1'b0;
            end
            if ($urandom % 8 == 0) idle(1 + $urandom % 3);
            do_fetch(a, lat, nreq);
        end
        idle(10);
        finish_run();
    end

endmodule